// File: doc/BRIEF.md
# Loopback and All-Ones Line Source Selector

This block sits between a host-side dual-rail data interface and a line coder / clock-and-data-recovery pair. On the transmit side it picks what the line coder receives next: the host's transmit symbols, the symbols just recovered from the receive line (remote loopback), or a generated alternating-mark all-ones pattern. On the receive side it picks what the host sees: the recovered symbols, or the host's own transmit symbols turned straight back (local loopback). It also chooses which bit-rate enable times each path, forwards the clock level and loss-of-lock indication that belong with the receive outputs, and tells the external coder and decoder whether to apply line coding (NRZ mode) or pass symbols through untouched (dual-rail mode).

All logic runs on one fast system clock. The transmit bit enable and the recovered bit enable are single-cycle strobes, one per bit period; each strobe acts as the valid of its stream. A line has no means to pause, so there is no ready signal and no back-pressure: every strobed symbol is taken in the cycle it is offered, and each registered output appears with a one-cycle valid pulse in the following cycle. All outputs are registered, and reset is asynchronous and active low.

Top module: `lbsel_top`

## Requirements
- R1: With no loopback and no all-ones, a `tx_bit_en` strobe loads {`tx_pos`,`tx_neg`} onto {`line_pos`,`line_neg`} with `line_valid` high one cycle later, and a `rec_bit_en` strobe loads {`rec_pos`,`rec_neg`} onto {`rx_pos`,`rx_neg`} with `rx_valid` high one cycle later.
- R2: In remote loopback (`rloop`=1, `lloop`=0, no all-ones) the line takes the recovered symbols, timed only by `rec_bit_en`; the host transmit symbols and `tx_bit_en` have no effect on the line, and the receive outputs still carry the recovered symbols.
- R3: In local loopback (`lloop`=1, `rloop`=0) the receive outputs take the host transmit symbols timed by `tx_bit_en`, `rx_clk` follows `tx_clk_lvl`, and the recovered symbols and `rec_bit_en` have no effect on the receive outputs; the line still carries host data.
- R4: With `all_ones`=1, each `tx_bit_en` strobe puts a mark on the line whose polarity alternates, positive being `line_pos`=1,`line_neg`=0 and negative being 0,1; the first mark after reset, or after `all_ones` was low at a clock edge, is positive. Host transmit data is ignored.
- R5: All-ones takes priority over either loopback on the line and is timed by `tx_bit_en` even in remote loopback; the receive side keeps its loopback behaviour (host data in local, recovered data in remote).
- R6: When `rloop` and `lloop` are both high the block behaves as with neither high, and `cfg_illegal` is 1 in the next cycle; otherwise `cfg_illegal` is 0 in the next cycle.
- R7: `line_encode` registers `nrz_mode` AND NOT `all_ones` every cycle (1 tells the coder to line-code the symbol), and `rx_decode` registers `nrz_mode` every cycle (1 tells the decoder to apply line decoding).
- R8: While `rst_n` is low: `rx_pos`, `rx_neg`, `line_pos`, `line_neg`, `line_valid`, `rx_valid`, `line_encode`, `rx_decode` and `cfg_illegal` are 0, and `rx_clk` and `rx_lol` are 1.
- R9: In a cycle without the path's selected strobe, the path's valid output is 0 and its symbol outputs hold their previous value.
- R10: Outside local loopback `rx_clk` registers `rec_clk_lvl`; in all modes `rx_lol` registers `rec_lol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nrz_mode | input | 1 | 1: single-rail host data with line coding; 0: dual-rail pass-through |
| all_ones | input | 1 | Transmit alternating-mark all-ones on the line |
| rloop | input | 1 | Remote loopback request |
| lloop | input | 1 | Local loopback request |
| tx_bit_en | input | 1 | Host transmit bit strobe (valid of the transmit stream) |
| tx_pos | input | 1 | Host transmit positive rail / NRZ data |
| tx_neg | input | 1 | Host transmit negative rail |
| tx_clk_lvl | input | 1 | Host transmit clock level |
| rec_bit_en | input | 1 | Recovered bit strobe (valid of the recovered stream) |
| rec_pos | input | 1 | Recovered positive rail |
| rec_neg | input | 1 | Recovered negative rail |
| rec_clk_lvl | input | 1 | Recovered clock level |
| rec_lol | input | 1 | Loss-of-lock from clock recovery |
| line_valid | output | 1 | New line symbol this cycle |
| line_pos | output | 1 | Line symbol, positive rail |
| line_neg | output | 1 | Line symbol, negative rail |
| line_encode | output | 1 | Coder must line-code the symbol |
| rx_valid | output | 1 | New receive symbol this cycle |
| rx_pos | output | 1 | Receive symbol, positive rail |
| rx_neg | output | 1 | Receive symbol, negative rail |
| rx_decode | output | 1 | Decoder must line-decode the symbol |
| rx_clk | output | 1 | Clock level belonging to the receive outputs |
| rx_lol | output | 1 | Loss-of-lock to the host |
| cfg_illegal | output | 1 | Both loopbacks were requested |

## Verification
The table walks every mode with rail values chosen so that host, recovered and held symbols differ, so a wrong source or a missing hold shows as a different rail pair. Strobes are offered singly as well as together, which separates a path timed by the correct enable from one timed by the other. All-ones rows run back to back across plain, local and remote settings and then restart after a both-loopbacks row, which tells polarity continuity apart from polarity restart. Directed tests cover the reset values, clock-level and loss-of-lock forwarding, and the first mark after a reset.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;

  typedef enum logic [1:0] {
    TXS_HOST      = 2'd0,
    TXS_RECOVERED = 2'd1,
    TXS_MARKS     = 2'd2
  } tx_src_e;

  typedef enum logic {
    RXS_LINE = 1'b0,
    RXS_HOST = 1'b1
  } rx_src_e;

  localparam rail_t RAIL_SPACE = '{pos: 1'b0, neg: 1'b0};
endpackage

// File: rtl/lbsel_ctrl.sv
module lbsel_ctrl
  import lbsel_pkg::*;
(
  input  logic    rloop,
  input  logic    lloop,
  input  logic    all_ones,
  output tx_src_e tx_src,
  output logic    tx_use_rec,
  output rx_src_e rx_src,
  output logic    illegal
);
  logic rl_eff;
  logic ll_eff;

  always_comb begin
    illegal = rloop & lloop;
    rl_eff  = rloop & ~lloop;
    ll_eff  = lloop & ~rloop;

    if (all_ones)    tx_src = TXS_MARKS;
    else if (rl_eff) tx_src = TXS_RECOVERED;
    else             tx_src = TXS_HOST;

    tx_use_rec = rl_eff & ~all_ones;
    rx_src     = ll_eff ? RXS_HOST : RXS_LINE;
  end
endmodule

// File: rtl/lbsel_marks.sv
module lbsel_marks
  import lbsel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  step,
  output rail_t mark
);
  logic next_is_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       next_is_neg <= 1'b0;
    else if (!enable) next_is_neg <= 1'b0;
    else if (step)    next_is_neg <= ~next_is_neg;
  end

  assign mark = '{pos: ~next_is_neg, neg: next_is_neg};
endmodule

// File: rtl/lbsel_tx_path.sv
module lbsel_tx_path
  import lbsel_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tx_src_e src,
  input  logic    use_rec,
  input  logic    tx_bit_en,
  input  logic    rec_bit_en,
  input  rail_t   host_sym,
  input  rail_t   rec_sym,
  input  rail_t   mark_sym,
  input  logic    encode_req,
  output logic    out_valid,
  output rail_t   out_sym,
  output logic    out_encode
);
  rail_t nxt_sym;
  logic  strobe;

  always_comb begin
    strobe = use_rec ? rec_bit_en : tx_bit_en;
    unique case (src)
      TXS_RECOVERED: nxt_sym = rec_sym;
      TXS_MARKS:     nxt_sym = mark_sym;
      default:       nxt_sym = host_sym;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sym    <= RAIL_SPACE;
      out_encode <= 1'b0;
    end else begin
      out_valid  <= strobe;
      out_encode <= encode_req;
      if (strobe) out_sym <= nxt_sym;
    end
  end
endmodule

// File: rtl/lbsel_rx_path.sv
module lbsel_rx_path
  import lbsel_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  rx_src_e src,
  input  logic    tx_bit_en,
  input  logic    rec_bit_en,
  input  rail_t   host_sym,
  input  rail_t   rec_sym,
  input  logic    tx_clk_lvl,
  input  logic    rec_clk_lvl,
  input  logic    rec_lol,
  input  logic    decode_req,
  output logic    out_valid,
  output rail_t   out_sym,
  output logic    out_decode,
  output logic    out_clk,
  output logic    out_lol
);
  logic  strobe;
  rail_t nxt_sym;
  logic  nxt_clk;

  always_comb begin
    if (src == RXS_HOST) begin
      strobe  = tx_bit_en;
      nxt_sym = host_sym;
      nxt_clk = tx_clk_lvl;
    end else begin
      strobe  = rec_bit_en;
      nxt_sym = rec_sym;
      nxt_clk = rec_clk_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sym    <= RAIL_SPACE;
      out_decode <= 1'b0;
      out_clk    <= 1'b1;
      out_lol    <= 1'b1;
    end else begin
      out_valid  <= strobe;
      out_decode <= decode_req;
      out_clk    <= nxt_clk;
      out_lol    <= rec_lol;
      if (strobe) out_sym <= nxt_sym;
    end
  end
endmodule

// File: rtl/lbsel_top.sv
module lbsel_top
  import lbsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nrz_mode,
  input  logic all_ones,
  input  logic rloop,
  input  logic lloop,
  input  logic tx_bit_en,
  input  logic tx_pos,
  input  logic tx_neg,
  input  logic tx_clk_lvl,
  input  logic rec_bit_en,
  input  logic rec_pos,
  input  logic rec_neg,
  input  logic rec_clk_lvl,
  input  logic rec_lol,
  output logic line_valid,
  output logic line_pos,
  output logic line_neg,
  output logic line_encode,
  output logic rx_valid,
  output logic rx_pos,
  output logic rx_neg,
  output logic rx_decode,
  output logic rx_clk,
  output logic rx_lol,
  output logic cfg_illegal
);
  tx_src_e tx_src;
  rx_src_e rx_src;
  logic    tx_use_rec;
  logic    illegal_now;
  rail_t   host_sym;
  rail_t   rec_sym;
  rail_t   mark_sym;
  rail_t   line_sym;
  rail_t   rx_sym;

  assign host_sym = '{pos: tx_pos, neg: tx_neg};
  assign rec_sym  = '{pos: rec_pos, neg: rec_neg};

  lbsel_ctrl u_ctrl (
    .rloop      (rloop),
    .lloop      (lloop),
    .all_ones   (all_ones),
    .tx_src     (tx_src),
    .tx_use_rec (tx_use_rec),
    .rx_src     (rx_src),
    .illegal    (illegal_now)
  );

  lbsel_marks u_marks (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (all_ones),
    .step   (all_ones & tx_bit_en),
    .mark   (mark_sym)
  );

  lbsel_tx_path u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (tx_src),
    .use_rec    (tx_use_rec),
    .tx_bit_en  (tx_bit_en),
    .rec_bit_en (rec_bit_en),
    .host_sym   (host_sym),
    .rec_sym    (rec_sym),
    .mark_sym   (mark_sym),
    .encode_req (nrz_mode & ~all_ones),
    .out_valid  (line_valid),
    .out_sym    (line_sym),
    .out_encode (line_encode)
  );

  lbsel_rx_path u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .src         (rx_src),
    .tx_bit_en   (tx_bit_en),
    .rec_bit_en  (rec_bit_en),
    .host_sym    (host_sym),
    .rec_sym     (rec_sym),
    .tx_clk_lvl  (tx_clk_lvl),
    .rec_clk_lvl (rec_clk_lvl),
    .rec_lol     (rec_lol),
    .decode_req  (nrz_mode),
    .out_valid   (rx_valid),
    .out_sym     (rx_sym),
    .out_decode  (rx_decode),
    .out_clk     (rx_clk),
    .out_lol     (rx_lol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_illegal <= 1'b0;
    else        cfg_illegal <= illegal_now;
  end

  assign line_pos = line_sym.pos;
  assign line_neg = line_sym.neg;
  assign rx_pos   = rx_sym.pos;
  assign rx_neg   = rx_sym.neg;
endmodule

// File: rtl/lbsel_checker.sv
module lbsel_checker (
  input logic clk,
  input logic rst_n,
  input logic nrz_mode,
  input logic all_ones,
  input logic rloop,
  input logic lloop,
  input logic tx_bit_en,
  input logic tx_pos,
  input logic tx_neg,
  input logic tx_clk_lvl,
  input logic rec_bit_en,
  input logic rec_pos,
  input logic rec_neg,
  input logic rec_clk_lvl,
  input logic rec_lol,
  input logic line_valid,
  input logic line_pos,
  input logic line_neg,
  input logic line_encode,
  input logic rx_valid,
  input logic rx_pos,
  input logic rx_neg,
  input logic rx_decode,
  input logic rx_clk,
  input logic rx_lol,
  input logic cfg_illegal
);
  logic reset_seen = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) reset_seen <= 1'b1;
  end

  AST_RESET_OUTPUTS: assert property (@(posedge clk)
    (!rst_n && reset_seen) |-> (rx_clk && rx_lol && !rx_pos && !rx_neg && !line_valid && !rx_valid)); // R8

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |-> $stable({line_pos, line_neg})); // R9

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable({rx_pos, rx_neg})); // R9

  AST_ONES_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && $past(all_ones)) |-> (line_pos != line_neg)); // R4

  AST_ILLEGAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rloop && lloop) |=> cfg_illegal); // R6

  AST_ILLEGAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(rloop && lloop) |=> !cfg_illegal); // R6

  AST_REMOTE_NO_HOST_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (rloop && !lloop && !all_ones && !rec_bit_en) |=> !line_valid); // R2

  AST_LOCAL_RX_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (lloop && !rloop && tx_bit_en) |=> (rx_valid && rx_pos == $past(tx_pos) && rx_neg == $past(tx_neg))); // R3

  AST_ENCODE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (nrz_mode && !all_ones) |=> line_encode); // R7

  AST_LOL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    rec_lol |=> rx_lol); // R10
endmodule

bind lbsel_top lbsel_checker u_chk (.*);

// File: tb/tb_lbsel_top.sv
module tb_lbsel_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nrz_mode = 0, all_ones = 0, rloop = 0, lloop = 0;
  logic tx_bit_en = 0, tx_pos = 0, tx_neg = 0, tx_clk_lvl = 0;
  logic rec_bit_en = 0, rec_pos = 0, rec_neg = 0, rec_clk_lvl = 0, rec_lol = 0;
  logic line_valid, line_pos, line_neg, line_encode;
  logic rx_valid, rx_pos, rx_neg, rx_decode, rx_clk, rx_lol, cfg_illegal;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  lbsel_top dut (.*);

  // [nrz aos rl ll]_[tp tn rp rn]_[ten ren]_[e_tv e_lp e_ln e_enc]_[e_rv e_rp e_rn e_dec]_[e_ill]
  typedef struct packed {
    logic nrz, aos, rl, ll, tp, tn, rp, rn, ten, ren;
    logic e_tv, e_lp, e_ln, e_enc, e_rv, e_rp, e_rn, e_dec, e_ill;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    19'b0000_1001_11_1100_1010_0,
    19'b1000_1010_11_1101_1101_0,
    19'b0000_0110_10_1010_0100_0,
    19'b0010_1001_10_0010_0100_0,
    19'b0010_0110_01_1100_1100_0,
    19'b0001_0110_11_1010_1010_0,
    19'b0001_1001_01_0010_0010_0,
    19'b0100_0000_10_1100_0010_0,
    19'b0100_1000_10_1010_0010_0,
    19'b0101_1000_10_1100_1100_0,
    19'b0110_0001_11_1010_1010_0,
    19'b0110_0010_01_0010_1100_0,
    19'b0110_0000_10_1100_0100_0,
    19'b0011_0110_11_1010_1100_1,
    19'b0100_0000_10_1100_0100_0,
    19'b1100_0000_10_1010_0101_0,
    19'b1001_1000_10_1101_1101_0
  };

  task automatic check(input string tag, input string what, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  function automatic string mode_tag(input vec_t v);
    if (v.rl && v.ll) return "R6";
    if (v.aos)        return (v.rl || v.ll) ? "R5" : "R4";
    if (v.rl)         return "R2";
    if (v.ll)         return "R3";
    return "R1";
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R8: reset values, observed while rst_n is low
    repeat (3) @(negedge clk);
    check("R8", "reset line", {1'b0, line_valid, line_pos, line_neg}, 4'b0000);
    check("R8", "reset rx",   {rx_valid, rx_pos, rx_neg, rx_decode}, 4'b0000);
    check("R8", "reset clk/lol/ill/enc", {rx_clk, rx_lol, cfg_illegal, line_encode}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      {nrz_mode, all_ones, rloop, lloop} = {v.nrz, v.aos, v.rl, v.ll};
      {tx_pos, tx_neg, rec_pos, rec_neg} = {v.tp, v.tn, v.rp, v.rn};
      {tx_bit_en, rec_bit_en} = {v.ten, v.ren};
      @(posedge clk);
      @(negedge clk);
      tx_bit_en  = 1'b0;
      rec_bit_en = 1'b0;
      check(v.e_tv ? mode_tag(v) : "R9", $sformatf("row %0d line", i),
            {1'b0, line_valid, line_pos, line_neg}, {1'b0, v.e_tv, v.e_lp, v.e_ln});
      check(v.e_rv ? mode_tag(v) : "R9", $sformatf("row %0d rx", i),
            {1'b0, rx_valid, rx_pos, rx_neg}, {1'b0, v.e_rv, v.e_rp, v.e_rn});
      check("R7", $sformatf("row %0d encode/decode", i),
            {2'b00, line_encode, rx_decode}, {2'b00, v.e_enc, v.e_dec});
      check("R6", $sformatf("row %0d illegal", i), {3'b000, cfg_illegal}, {3'b000, v.e_ill});
    end

    // R10: clock level and loss-of-lock forwarding in normal mode
    {nrz_mode, all_ones, rloop, lloop} = 4'b0000;
    tx_clk_lvl = 1'b1; rec_clk_lvl = 1'b0; rec_lol = 1'b1;
    @(negedge clk);
    check("R10", "normal clk/lol", {2'b00, rx_clk, rx_lol}, 4'b0001);
    rec_clk_lvl = 1'b1; tx_clk_lvl = 1'b0; rec_lol = 1'b0;
    @(negedge clk);
    check("R10", "normal clk follows recovered", {2'b00, rx_clk, rx_lol}, 4'b0010);

    // R3: local loopback takes the host clock level
    lloop = 1'b1;
    @(negedge clk);
    check("R3", "local clk follows host", {2'b00, rx_clk, rx_lol}, 4'b0000);
    lloop = 1'b0;

    // R4: first mark after a mid-run reset is positive
    all_ones = 1'b1; tx_bit_en = 1'b1;
    @(negedge clk);
    tx_bit_en = 1'b0;
    check("R4", "mark before reset", {1'b0, line_valid, line_pos, line_neg}, 4'b0110);
    rst_n = 1'b0;
    #1;
    check("R8", "async reset line", {1'b0, line_valid, line_pos, line_neg}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tx_bit_en = 1'b1;
    @(negedge clk);
    tx_bit_en = 1'b0;
    check("R4", "first mark after reset", {1'b0, line_valid, line_pos, line_neg}, 4'b0110);
    tx_bit_en = 1'b1;
    @(negedge clk);
    tx_bit_en = 1'b0;
    check("R4", "second mark after reset", {1'b0, line_valid, line_pos, line_neg}, 4'b0101);

    done = 1'b1;
    finish_run();
  end
endmodule